// File: doc/BRIEF.md
# Fractional UART Bit-Timing Generator

This block produces the timing strobes that pace one UART frame, separately for the transmit and the receive direction. A shared 8-bit divisor sets the length of one oversampling tick: a tick lasts divisor+1 clock cycles. A nominal bit lasts 16 ticks. Each bit position of the frame also has its own 2-bit adjustment code, which makes that bit one tick longer or one tick shorter. Averaged over the frame, this gives bit rates that the integer divisor alone cannot reach. For example, with a 12 MHz clock, divisor 6 and every position shortened, each bit lasts 105 cycles, which is about 114.3 kbit/s.

Each direction has its own pattern, frame length and start strobe. A start strobe captures the divisor, the pattern and the length, and it restarts the tick and bit counters. The direction then raises a tick strobe on every oversampling tick and a bit-end strobe on the last tick of each bit. It also reports the current bit position until the last position has ended. A serializer or deserializer placed next to the block shifts on the bit-end strobe and samples on the tick strobe.

Top module: `fbr_bit_timer`

## Requirements
- R1: After reset, both directions are idle: busy low, tick and bit-end strobes low, bit index 0.
- R2: While a frame runs, the tick strobe is high for one cycle every divisor+1 clock cycles. The first tick comes divisor+1 cycles after the clock edge that captured the start strobe.
- R3: A bit position whose code is 2 or 0 lasts 16 ticks.
- R4: A bit position whose code is 1 lasts 17 ticks.
- R5: A bit position whose code is 3 lasts 15 ticks. With divisor 6, such a bit lasts 105 clock cycles.
- R6: Bit position k, counted from 0 for the start bit, takes its code from pattern bits [2k+1:2k]. The bit index output shows k while position k runs and stays unchanged between bit ends. The bit-end strobe is high on the last tick of each position.
- R7: A frame covers the captured length in positions. A length of 0 counts as 1, and a length above 12 counts as 12. After the bit end of the last position, busy drops and the index returns to 0. Pattern bits of positions beyond the length have no effect.
- R8: A start strobe during a frame aborts it and begins a new frame from position 0, with a fresh tick count and a fresh prescaler.
- R9: Divisor, pattern and length are captured only at the start strobe. Changes to them during a frame do not alter that frame.
- R10: The two directions run independently. Activity in one direction does not change the timing of the other.
- R11: No tick or bit-end strobe appears while a direction is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Shared divisor, ticks last div_i+1 cycles |
| tx_pat_i | input | 2*MAX_POS | Transmit adjustment codes, 2 bits per position |
| rx_pat_i | input | 2*MAX_POS | Receive adjustment codes, 2 bits per position |
| tx_len_i | input | IDX_W | Transmit frame length in bit positions |
| rx_len_i | input | IDX_W | Receive frame length in bit positions |
| tx_start_i | input | 1 | Transmit frame start strobe |
| rx_start_i | input | 1 | Receive frame start strobe |
| tx_tick_o | output | 1 | Transmit oversampling tick |
| tx_bit_end_o | output | 1 | Transmit last tick of a bit |
| tx_bit_idx_o | output | IDX_W | Transmit current bit position |
| tx_busy_o | output | 1 | Transmit frame in progress |
| rx_tick_o | output | 1 | Receive oversampling tick |
| rx_bit_end_o | output | 1 | Receive last tick of a bit |
| rx_bit_idx_o | output | IDX_W | Receive current bit position |
| rx_busy_o | output | 1 | Receive frame in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor and 12 bit positions, so the pattern is 24 bits and the length field is 4 bits wide. The 4-bit length field makes the out-of-range values 0, 13 and 15 reachable, and these exercise the clamp. Small divisors from 0 to 6 keep every frame short, so all four adjustment codes, a full 12-position frame and the 105-cycle shortened bit fit into one run. Each expected bit end is computed in cycles from the captured configuration and compared with the cycle in which it appears. The tick spacing is compared the same way.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // Oversampling ticks in a nominal bit
    localparam int OVS_TICKS  = 16;
    // Counter width able to hold a stretched bit (17 ticks)
    localparam int TICK_CNT_W = $clog2(OVS_TICKS + 2);
    // Number of directions served (transmit, receive)
    localparam int N_DIR      = 2;

    typedef enum logic [1:0] {
        ADJ_KEEP0   = 2'd0,
        ADJ_STRETCH = 2'd1,
        ADJ_KEEP    = 2'd2,
        ADJ_SHRINK  = 2'd3
    } adj_code_e;

    typedef struct packed {
        logic tick;
        logic bit_end;
        logic busy;
    } chan_flags_t;

    // Index of the final tick in a bit for a given adjustment code
    function automatic logic [TICK_CNT_W-1:0] last_tick_of(adj_code_e code);
        case (code)
            ADJ_STRETCH: return TICK_CNT_W'(OVS_TICKS);
            ADJ_SHRINK:  return TICK_CNT_W'(OVS_TICKS - 2);
            default:     return TICK_CNT_W'(OVS_TICKS - 1);
        endcase
    endfunction

    // Map a raw frame length into the legal range 1..max_pos
    function automatic int clamp_len(int raw, int max_pos);
        if (raw < 1)
            return 1;
        else if (raw > max_pos)
            return max_pos;
        else
            return raw;
    endfunction

endpackage

// File: rtl/fbr_prescaler.sv
module fbr_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (tick)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fbr_bit_seq.sv
module fbr_bit_seq
    import fbr_pkg::*;
#(
    parameter int MAX_POS = 12,
    parameter int IDX_W   = 4,
    parameter int PAT_W   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [IDX_W-1:0] len_i,
    output logic             busy,
    output logic             bit_end,
    output logic [IDX_W-1:0] idx
);

    logic [PAT_W-1:0]      pat_q;
    logic [IDX_W-1:0]      len_q;
    logic [IDX_W-1:0]      idx_q;
    logic [TICK_CNT_W-1:0] tcnt_q;
    logic                  busy_q;

    adj_code_e             code;
    logic [TICK_CNT_W-1:0] last_tick;
    logic                  at_last_tick;
    logic                  at_last_pos;

    // Select the code of the running position
    always_comb begin
        code = ADJ_KEEP;
        for (int k = 0; k < MAX_POS; k++) begin
            if (idx_q == IDX_W'(k))
                code = adj_code_e'(pat_q[2*k +: 2]);
        end
    end

    assign last_tick    = last_tick_of(code);
    assign at_last_tick = (tcnt_q == last_tick);
    assign at_last_pos  = (idx_q == len_q - 1'b1);

    assign bit_end = busy_q && tick && at_last_tick;
    assign busy    = busy_q;
    assign idx     = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            tcnt_q <= '0;
            pat_q  <= '0;
            len_q  <= IDX_W'(1);
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            tcnt_q <= '0;
            pat_q  <= pat_i;
            len_q  <= IDX_W'(clamp_len(int'(len_i), MAX_POS));
        end else if (busy_q && tick) begin
            if (at_last_tick) begin
                tcnt_q <= '0;
                if (at_last_pos) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                end
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fbr_channel.sv
module fbr_channel
    import fbr_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int MAX_POS = 12,
    parameter int IDX_W   = 4,
    parameter int PAT_W   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [IDX_W-1:0] len_i,
    output chan_flags_t      flags,
    output logic [IDX_W-1:0] idx
);

    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             busy;
    logic             bit_end;

    // The divisor is held for the whole frame
    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (start)
            div_q <= div_i;
    end

    fbr_prescaler #(
        .DIV_W (DIV_W)
    ) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    fbr_bit_seq #(
        .MAX_POS (MAX_POS),
        .IDX_W   (IDX_W),
        .PAT_W   (PAT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .pat_i   (pat_i),
        .len_i   (len_i),
        .busy    (busy),
        .bit_end (bit_end),
        .idx     (idx)
    );

    assign flags.tick    = tick;
    assign flags.bit_end = bit_end;
    assign flags.busy    = busy;

endmodule

// File: rtl/fbr_bit_timer.sv
module fbr_bit_timer
    import fbr_pkg::*;
#(
    parameter  int DIV_W   = 8,
    parameter  int MAX_POS = 12,
    localparam int IDX_W   = $clog2(MAX_POS + 1),
    localparam int PAT_W   = 2 * MAX_POS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PAT_W-1:0] tx_pat_i,
    input  logic [PAT_W-1:0] rx_pat_i,
    input  logic [IDX_W-1:0] tx_len_i,
    input  logic [IDX_W-1:0] rx_len_i,
    input  logic             tx_start_i,
    input  logic             rx_start_i,
    output logic             tx_tick_o,
    output logic             tx_bit_end_o,
    output logic [IDX_W-1:0] tx_bit_idx_o,
    output logic             tx_busy_o,
    output logic             rx_tick_o,
    output logic             rx_bit_end_o,
    output logic [IDX_W-1:0] rx_bit_idx_o,
    output logic             rx_busy_o
);

    logic             start_a [N_DIR];
    logic [PAT_W-1:0] pat_a   [N_DIR];
    logic [IDX_W-1:0] len_a   [N_DIR];
    chan_flags_t      flags_a [N_DIR];
    logic [IDX_W-1:0] idx_a   [N_DIR];

    assign start_a[0] = tx_start_i;
    assign start_a[1] = rx_start_i;
    assign pat_a[0]   = tx_pat_i;
    assign pat_a[1]   = rx_pat_i;
    assign len_a[0]   = tx_len_i;
    assign len_a[1]   = rx_len_i;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        fbr_channel #(
            .DIV_W   (DIV_W),
            .MAX_POS (MAX_POS),
            .IDX_W   (IDX_W),
            .PAT_W   (PAT_W)
        ) u_chan (
            .clk   (clk),
            .rst   (rst),
            .start (start_a[g]),
            .div_i (div_i),
            .pat_i (pat_a[g]),
            .len_i (len_a[g]),
            .flags (flags_a[g]),
            .idx   (idx_a[g])
        );
    end

    assign tx_tick_o    = flags_a[0].tick;
    assign tx_bit_end_o = flags_a[0].bit_end;
    assign tx_busy_o    = flags_a[0].busy;
    assign tx_bit_idx_o = idx_a[0];
    assign rx_tick_o    = flags_a[1].tick;
    assign rx_bit_end_o = flags_a[1].bit_end;
    assign rx_busy_o    = flags_a[1].busy;
    assign rx_bit_idx_o = idx_a[1];

endmodule

// File: rtl/fbr_chan_chk.sv
module fbr_chan_chk #(
    parameter int MAX_POS = 12,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tick,
    input logic             bit_end,
    input logic             busy,
    input logic [IDX_W-1:0] idx
);

    // R8: a start strobe always opens a frame at position 0
    a_r8_start_opens: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && idx == '0));

    // R11: strobes only while a frame is running
    a_r11_tick_needs_busy: assert property (@(posedge clk) disable iff (rst)
        tick |-> busy);

    // R6: a bit end always falls on a tick
    a_r6_end_on_tick: assert property (@(posedge clk) disable iff (rst)
        bit_end |-> tick);

    // R6: the index is held between bit ends
    a_r6_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !bit_end) |=> $stable(idx));

    // R6: a bit end advances the index or closes the frame
    a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
        (bit_end && !start) |=> (!busy || idx == $past(idx) + 1'b1));

    // R7: the index never passes the last legal position
    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < IDX_W'(MAX_POS)));

    // R7: an idle direction reports position 0
    a_r7_idle_idx: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (idx == '0));

    // R7: a frame only closes on a bit end
    a_r7_close_on_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(bit_end));

endmodule

bind fbr_bit_timer fbr_chan_chk #(
    .MAX_POS (MAX_POS),
    .IDX_W   (IDX_W)
) u_chk_tx (
    .clk     (clk),
    .rst     (rst),
    .start   (tx_start_i),
    .tick    (tx_tick_o),
    .bit_end (tx_bit_end_o),
    .busy    (tx_busy_o),
    .idx     (tx_bit_idx_o)
);

bind fbr_bit_timer fbr_chan_chk #(
    .MAX_POS (MAX_POS),
    .IDX_W   (IDX_W)
) u_chk_rx (
    .clk     (clk),
    .rst     (rst),
    .start   (rx_start_i),
    .tick    (rx_tick_o),
    .bit_end (rx_bit_end_o),
    .busy    (rx_busy_o),
    .idx     (rx_bit_idx_o)
);

// File: tb/fbr_bit_timer_tb_top.sv
module fbr_bit_timer_tb_top;

    localparam int DIV_W   = 8;
    localparam int MAX_POS = 12;
    localparam int IDX_W   = $clog2(MAX_POS + 1);
    localparam int PAT_W   = 2 * MAX_POS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_i = '0;
    logic [PAT_W-1:0] tx_pat_i = '0;
    logic [PAT_W-1:0] rx_pat_i = '0;
    logic [IDX_W-1:0] tx_len_i = '0;
    logic [IDX_W-1:0] rx_len_i = '0;
    logic             tx_start_i = 1'b0;
    logic             rx_start_i = 1'b0;
    logic             tx_tick_o, tx_bit_end_o, tx_busy_o;
    logic             rx_tick_o, rx_bit_end_o, rx_busy_o;
    logic [IDX_W-1:0] tx_bit_idx_o, rx_bit_idx_o;

    always #10 clk = ~clk;

    fbr_bit_timer #(
        .DIV_W   (DIV_W),
        .MAX_POS (MAX_POS)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .div_i        (div_i),
        .tx_pat_i     (tx_pat_i),
        .rx_pat_i     (rx_pat_i),
        .tx_len_i     (tx_len_i),
        .rx_len_i     (rx_len_i),
        .tx_start_i   (tx_start_i),
        .rx_start_i   (rx_start_i),
        .tx_tick_o    (tx_tick_o),
        .tx_bit_end_o (tx_bit_end_o),
        .tx_bit_idx_o (tx_bit_idx_o),
        .tx_busy_o    (tx_busy_o),
        .rx_tick_o    (rx_tick_o),
        .rx_bit_end_o (rx_bit_end_o),
        .rx_bit_idx_o (rx_bit_idx_o),
        .rx_busy_o    (rx_busy_o)
    );

    typedef struct {
        int at;
        int idx;
        bit last;
    } exp_t;

    exp_t  q_tx[$];
    exp_t  q_rx[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    start_cyc [2];
    int    next_tick [2];
    int    period    [2];
    int    tick_cnt  [2];
    int    tick_bad  [2];
    int    idle_bad  [2];
    int    exp_ticks [2];
    bit    exp_busy  [2];
    string cur_tag   [2];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int code_ticks(logic [1:0] c);
        if (c == 2'd1) return 17;
        if (c == 2'd3) return 15;
        return 16;
    endfunction

    function automatic int legal_len(int raw);
        if (raw < 1) return 1;
        if (raw > MAX_POS) return MAX_POS;
        return raw;
    endfunction

    // Monitor: compares the observed strobes against the scoreboard
    task automatic observe(int ch, logic tk, logic be, logic [IDX_W-1:0] ix);
        exp_t it;
        bit   have;
        if ((tk || be) && !exp_busy[ch])
            idle_bad[ch]++;
        if (tk && cyc > start_cyc[ch]) begin
            tick_cnt[ch]++;
            if (cyc != next_tick[ch])
                tick_bad[ch]++;
            next_tick[ch] = next_tick[ch] + period[ch];
        end
        if (be) begin
            have = 1'b0;
            if (ch == 0 && q_tx.size() > 0) begin
                it = q_tx.pop_front();
                have = 1'b1;
            end else if (ch == 1 && q_rx.size() > 0) begin
                it = q_rx.pop_front();
                have = 1'b1;
            end
            if (!have) begin
                chk(1'b0, cur_tag[ch], "unexpected bit end at cycle", cyc, -1);
            end else begin
                chk(it.at == cyc, cur_tag[ch], "bit end cycle", cyc, it.at);
                chk(int'(ix) == it.idx, cur_tag[ch], "bit index at bit end",
                    int'(ix), it.idx);
                if (it.last)
                    exp_busy[ch] = 1'b0;
            end
        end
    endtask

    always @(negedge clk) begin
        observe(0, tx_tick_o, tx_bit_end_o, tx_bit_idx_o);
        observe(1, rx_tick_o, rx_bit_end_o, rx_bit_idx_o);
    end

    // Driver: computes the expected bit ends and starts a frame
    task automatic launch(int ch, int d, logic [PAT_W-1:0] pat, int len, string tag);
        int s;
        int n;
        int cum;
        exp_t it;
        @(posedge clk);
        #1;
        s = cyc;
        n = legal_len(len);
        if (ch == 0) begin
            while (q_tx.size() > 0 && q_tx[$].at > s) void'(q_tx.pop_back());
        end else begin
            while (q_rx.size() > 0 && q_rx[$].at > s) void'(q_rx.pop_back());
        end
        cum = 0;
        for (int k = 0; k < n; k++) begin
            cum += code_ticks(pat[2*k +: 2]);
            it.at = s + (d + 1) * cum;
            it.idx = k;
            it.last = (k == n - 1);
            if (ch == 0) q_tx.push_back(it);
            else q_rx.push_back(it);
        end
        start_cyc[ch] = s;
        next_tick[ch] = s + d + 1;
        period[ch]    = d + 1;
        tick_cnt[ch]  = 0;
        tick_bad[ch]  = 0;
        exp_ticks[ch] = cum;
        exp_busy[ch]  = 1'b1;
        cur_tag[ch]   = tag;
        div_i = DIV_W'(d);
        if (ch == 0) begin
            tx_pat_i = pat;
            tx_len_i = IDX_W'(len);
            tx_start_i = 1'b1;
        end else begin
            rx_pat_i = pat;
            rx_len_i = IDX_W'(len);
            rx_start_i = 1'b1;
        end
        @(posedge clk);
        #1;
        tx_start_i = 1'b0;
        rx_start_i = 1'b0;
    endtask

    task automatic finish_frame(int ch);
        logic bz;
        for (int w = 0; w < 20000 && exp_busy[ch]; w++) @(negedge clk);
        chk(!exp_busy[ch], cur_tag[ch], "frame completed (pending flag)",
            int'(exp_busy[ch]), 0);
        @(negedge clk);
        bz = (ch == 0) ? tx_busy_o : rx_busy_o;
        chk(bz == 1'b0, "R7", "busy after last bit end", int'(bz), 0);
        chk(tick_cnt[ch] == exp_ticks[ch], "R2", "ticks in frame",
            tick_cnt[ch], exp_ticks[ch]);
        chk(tick_bad[ch] == 0, "R2", "ticks off the divisor grid",
            tick_bad[ch], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            start_cyc[c] = 0; next_tick[c] = 0; period[c] = 1;
            tick_cnt[c] = 0; tick_bad[c] = 0; idle_bad[c] = 0;
            exp_ticks[c] = 0; exp_busy[c] = 1'b0; cur_tag[c] = "R11";
        end
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(tx_busy_o == 1'b0, "R1", "tx busy", int'(tx_busy_o), 0);
        chk(rx_busy_o == 1'b0, "R1", "rx busy", int'(rx_busy_o), 0);
        chk(tx_tick_o == 1'b0 && tx_bit_end_o == 1'b0, "R1", "tx strobes",
            int'({tx_tick_o, tx_bit_end_o}), 0);
        chk(rx_tick_o == 1'b0 && rx_bit_end_o == 1'b0, "R1", "rx strobes",
            int'({rx_tick_o, rx_bit_end_o}), 0);
        chk(tx_bit_idx_o == '0 && rx_bit_idx_o == '0, "R1", "bit indices",
            int'({tx_bit_idx_o, rx_bit_idx_o}), 0);

        // R3: all positions code 2, and all positions code 0
        launch(0, 2, 24'hAAAAAA, 10, "R3");
        finish_frame(0);
        launch(0, 1, 24'h000000, 7, "R3");
        finish_frame(0);

        // R5: all positions code 3 with divisor 6, 105 cycles per bit
        launch(0, 6, 24'hFFFFFF, 10, "R5");
        finish_frame(0);

        // R4: all positions code 1, divisor 0, full 12-position frame
        launch(0, 0, 24'h555555, 12, "R4");
        finish_frame(0);

        // R6: mixed codes, per-position selection
        launch(0, 2, 24'h3C9D71, 11, "R6");
        finish_frame(0);

        // R7: clamp above and below, unused pattern bits ignored
        launch(0, 1, 24'h6B4E1D, 15, "R7");
        finish_frame(0);
        launch(1, 3, 24'hFFFFF5, 0, "R7");
        finish_frame(1);
        launch(0, 2, 24'h55D2A6, 7, "R7");
        finish_frame(0);

        // R8: restart in the middle of a frame
        launch(0, 2, 24'hAAAAAA, 10, "R8");
        repeat (200) @(posedge clk);
        launch(0, 1, 24'h555555, 8, "R8");
        finish_frame(0);

        // R9: inputs changed during the frame are ignored
        launch(1, 3, 24'hAAAAAA, 9, "R9");
        repeat (30) @(posedge clk);
        #1;
        div_i = '0;
        rx_pat_i = 24'hFFFFFF;
        rx_len_i = IDX_W'(12);
        finish_frame(1);

        // R10: both directions at once with different settings
        launch(0, 1, 24'h555555, 8, "R10");
        launch(1, 4, 24'hFFFFFF, 11, "R10");
        finish_frame(0);
        finish_frame(1);

        // R11: no strobes while idle
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(idle_bad[0] == 0, "R11", "tx strobes while idle", idle_bad[0], 0);
        chk(idle_bad[1] == 0, "R11", "rx strobes while idle", idle_bad[1], 0);
        chk(q_tx.size() == 0 && q_rx.size() == 0, "R10", "unmatched bit ends",
            q_tx.size() + q_rx.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule